// File: doc/BRIEF.md
# Condition-Code Branch Unit

This block decides, one instruction at a time, whether a conditional branch is taken, and it computes where control goes. It reads three status flags: zero, carry and negative. A 5-bit condition field states which of those flags must be set or clear. Two branch forms are supported. The relative form adds a signed short offset to the address of the next instruction. The absolute form takes its destination from a register value.

A small sequencer holds the program counter for an instruction-fetch stub. When a branch is taken, the instruction right after it still runs, in a single delay slot. The new address is loaded only once that slot instruction has executed. A branch found inside a delay slot does nothing and raises an error pulse.

An upstream stage presents one instruction per cycle with `instr_valid` high. It reads `pc` to find out which address it is executing.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc` equals the RESET_PC parameter (default 0) and `taken`, `target`, `in_slot` and `slot_error` are all 0.
- R2: A cycle with `instr_valid` low changes no state. `pc`, `target` and `in_slot` keep their values, and `taken` and `slot_error` are 0 after that edge.
- R3: Outside a delay slot, an instruction whose `instr_kind` is 0 (plain) or 3 (also plain) advances `pc` by 2. A branch whose condition fails also advances `pc` by 2. In both cases `in_slot` stays 0.
- R4: `flags` carries zero in bit 0, carry in bit 1 and negative in bit 2. Condition bit 0 demands that zero be clear, and condition bit 1 demands that zero be set.
- R5: Condition bit 4 selects the tested flag: carry when it is 0, negative when it is 1. Condition bit 2 demands that the tested flag be clear, and condition bit 3 demands that it be set.
- R6: A condition of 0 is always taken. A condition that demands a flag be both set and clear (bits 0 and 1 together, or bits 2 and 3 together) is never taken.
- R7: For `instr_kind` 1 (relative), the target is `pc + 2 + 2*offset` modulo 2^24, where `rel_offset` is a two's-complement value from -16 to 15.
- R8: For `instr_kind` 2 (absolute), the target is `jump_reg` bits 23..0 with bit 0 forced to 0.
- R9: After the edge that executes a taken branch, `taken` pulses for one cycle, `target` holds the destination, `in_slot` is 1 and `pc` is the branch address plus 2. After the next executed instruction, `pc` equals that target and `in_slot` returns to 0.
- R10: A branch (kind 1 or 2) executed in a delay slot is not evaluated. `taken` stays 0, `slot_error` pulses for one cycle, and `pc` still moves to the pending target.
- R11: A cycle with `instr_valid` low inside a delay slot keeps the slot pending. The redirect happens on the next valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction at `pc` executes this cycle |
| instr_kind | input | 2 | 0/3 plain, 1 relative branch, 2 absolute jump |
| cond_code | input | 5 | Flag requirements of the branch |
| rel_offset | input | 5 | Signed offset in instruction units |
| jump_reg | input | 32 | Register value for absolute jumps |
| flags | input | 3 | {negative, carry, zero} |
| pc | output | 24 | Address of the instruction now executing |
| taken | output | 1 | One-cycle pulse after a taken branch |
| target | output | 24 | Latest taken destination |
| in_slot | output | 1 | Next executed instruction is a delay slot |
| slot_error | output | 1 | One-cycle pulse: branch seen in a delay slot |

## Verification
The redirect that ends a delay slot can fall in the same cycle as a fresh branch decision. This happens whenever the slot instruction is itself a branch. The bench provokes this by placing both an absolute jump and a relative branch, each with conditions that would pass, directly behind taken branches. It also places an idle cycle inside a slot before one such case. In each case the scoreboard expects `pc` to land on the earlier branch's destination, `taken` to stay low and `slot_error` to pulse. It also expects `target` to keep the earlier value rather than the one the slot branch would have produced.

// File: rtl/cc_branch_pkg.sv
package cc_branch_pkg;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_REL   = 2'd1,
        KIND_ABS   = 2'd2,
        KIND_SPARE = 2'd3
    } instr_kind_e;

    // positions inside the flag vector
    localparam int FLAG_ZERO  = 0;
    localparam int FLAG_CARRY = 1;
    localparam int FLAG_NEG   = 2;

    // positions inside the condition field
    localparam int CC_ZCLR = 0;
    localparam int CC_ZSET = 1;
    localparam int CC_FCLR = 2;
    localparam int CC_FSET = 3;
    localparam int CC_FSEL = 4;

    function automatic logic is_branch(input logic [1:0] kind);
        return (kind == KIND_REL) || (kind == KIND_ABS);
    endfunction

endpackage

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
    import cc_branch_pkg::*;
#(
    parameter int CC_W   = 5,
    parameter int FLAG_W = 3
) (
    input  logic [CC_W-1:0]   cond_code,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);
    logic zero_f;
    logic sel_f;
    logic zero_ok;
    logic sel_ok;

    always_comb begin
        zero_f  = flags[FLAG_ZERO];
        sel_f   = cond_code[CC_FSEL] ? flags[FLAG_NEG] : flags[FLAG_CARRY];
        zero_ok = !(cond_code[CC_ZCLR] && zero_f) && !(cond_code[CC_ZSET] && !zero_f);
        sel_ok  = !(cond_code[CC_FCLR] && sel_f)  && !(cond_code[CC_FSET] && !sel_f);
        pass    = zero_ok && sel_ok;
    end

endmodule

// File: rtl/cc_target_calc.sv
module cc_target_calc
    import cc_branch_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 5,
    parameter int REG_W  = 32
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [REG_W-1:0]  jump_reg,
    output logic [ADDR_W-1:0] dest
);
    localparam int          EXT_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] rel_dest;
    logic [ADDR_W-1:0] abs_dest;

    always_comb begin
        off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
        rel_dest = pc + STEP + (off_ext << 1);
        abs_dest = {jump_reg[ADDR_W-1:1], 1'b0};
        dest     = (kind == KIND_ABS) ? abs_dest : rel_dest;
    end

endmodule

// File: rtl/cc_slot_seq.sv
module cc_slot_seq
    import cc_branch_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter logic [23:0]     RESET_PC = 24'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              branch_now,
    input  logic              cond_pass,
    input  logic [ADDR_W-1:0] dest,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              in_slot_o,
    output logic              taken_o,
    output logic              slot_err_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] target;
        logic              in_slot;
        logic              taken;
        logic              slot_err;
    } seq_state_t;

    seq_state_t state_d;
    seq_state_t state_q;

    always_comb begin
        state_d          = state_q;
        state_d.taken    = 1'b0;
        state_d.slot_err = 1'b0;
        if (instr_valid) begin
            if (state_q.in_slot) begin
                state_d.pc       = state_q.target;
                state_d.in_slot  = 1'b0;
                state_d.slot_err = branch_now;
            end else if (branch_now && cond_pass) begin
                state_d.pc      = state_q.pc + STEP;
                state_d.target  = dest;
                state_d.in_slot = 1'b1;
                state_d.taken   = 1'b1;
            end else begin
                state_d.pc = state_q.pc + STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc       <= ADDR_W'(RESET_PC);
            state_q.target   <= '0;
            state_q.in_slot  <= 1'b0;
            state_q.taken    <= 1'b0;
            state_q.slot_err <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign target_o   = state_q.target;
    assign in_slot_o  = state_q.in_slot;
    assign taken_o    = state_q.taken;
    assign slot_err_o = state_q.slot_err;

endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_branch_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          OFF_W    = 5,
    parameter int          CC_W     = 5,
    parameter int          FLAG_W   = 3,
    parameter int          REG_W    = 32,
    parameter logic [23:0] RESET_PC = 24'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [1:0]        instr_kind,
    input  logic [CC_W-1:0]   cond_code,
    input  logic [OFF_W-1:0]  rel_offset,
    input  logic [REG_W-1:0]  jump_reg,
    input  logic [FLAG_W-1:0] flags,
    output logic [ADDR_W-1:0] pc,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              in_slot,
    output logic              slot_error
);
    logic              cond_pass;
    logic [ADDR_W-1:0] dest;
    logic              branch_now;

    assign branch_now = is_branch(instr_kind);

    cc_cond_eval #(.CC_W(CC_W), .FLAG_W(FLAG_W)) u_cond (
        .cond_code (cond_code),
        .flags     (flags),
        .pass      (cond_pass)
    );

    cc_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REG_W(REG_W)) u_tgt (
        .kind     (instr_kind),
        .pc       (pc),
        .offset   (rel_offset),
        .jump_reg (jump_reg),
        .dest     (dest)
    );

    cc_slot_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .branch_now  (branch_now),
        .cond_pass   (cond_pass),
        .dest        (dest),
        .pc_o        (pc),
        .target_o    (target),
        .in_slot_o   (in_slot),
        .taken_o     (taken),
        .slot_err_o  (slot_error)
    );

endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [1:0]        instr_kind,
    input logic [ADDR_W-1:0] pc,
    input logic              taken,
    input logic [ADDR_W-1:0] target,
    input logic              in_slot,
    input logic              slot_error
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    // R2: idle cycle leaves the program counter and slot state alone
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(pc) && $stable(in_slot) && !taken && !slot_error));

    // R3: plain instruction outside a slot steps by one instruction
    assert_plain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !in_slot && (instr_kind == 2'd0 || instr_kind == 2'd3))
        |=> (pc == $past(pc) + STEP) && !in_slot);

    // R9: a taken pulse always opens a delay slot
    assert_taken_opens_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> in_slot);

    // R9: executing the slot instruction lands on the held target
    assert_slot_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && instr_valid) |=> (pc == $past(target)) && !in_slot);

    // R10: a slot error never coincides with a taken pulse
    assert_slot_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_error |-> !taken);

    // R10: the error pulse lasts one cycle only
    assert_slot_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_error |=> !slot_error);

endmodule

bind cc_branch_unit cc_branch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_kind  (instr_kind),
    .pc          (pc),
    .taken       (taken),
    .target      (target),
    .in_slot     (in_slot),
    .slot_error  (slot_error)
);

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [1:0]  instr_kind;
    logic [4:0]  cond_code;
    logic [4:0]  rel_offset;
    logic [31:0] jump_reg;
    logic [2:0]  flags;
    logic [23:0] pc;
    logic        taken;
    logic [23:0] target;
    logic        in_slot;
    logic        slot_error;

    always #10 clk = ~clk;

    cc_branch_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_kind  (instr_kind),
        .cond_code   (cond_code),
        .rel_offset  (rel_offset),
        .jump_reg    (jump_reg),
        .flags       (flags),
        .pc          (pc),
        .taken       (taken),
        .target      (target),
        .in_slot     (in_slot),
        .slot_error  (slot_error)
    );

    typedef struct {
        logic [23:0] pc;
        logic        taken;
        logic [23:0] target;
        logic        in_slot;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    // bench-side reference state
    int   m_pc   = 0;
    int   m_tgt  = 0;
    bit   m_slot = 0;

    function automatic bit cond_ok(input logic [4:0] cc, input logic [2:0] fl);
        bit z, f, ok;
        z  = fl[0];
        f  = cc[4] ? fl[2] : fl[1];
        ok = 1;
        if (cc[0] && z)  ok = 0;
        if (cc[1] && !z) ok = 0;
        if (cc[2] && f)  ok = 0;
        if (cc[3] && !f) ok = 0;
        return ok;
    endfunction

    task automatic drive(input logic v, input logic [1:0] k, input logic [4:0] cc,
                         input logic [4:0] off, input logic [31:0] r,
                         input logic [2:0] fl, input string tag);
        exp_t e;
        int   so;
        bit   br;
        @(negedge clk);
        instr_valid = v; instr_kind = k; cond_code = cc;
        rel_offset = off; jump_reg = r; flags = fl;
        br = (k == 2'd1) || (k == 2'd2);
        e.taken = 0; e.err = 0; e.tag = tag;
        if (v) begin
            if (m_slot) begin
                m_pc   = m_tgt;
                m_slot = 0;
                e.err  = br;
            end else if (br && cond_ok(cc, fl)) begin
                so = off[4] ? int'(off) - 32 : int'(off);
                if (k == 2'd1) m_tgt = (m_pc + 2 + 2 * so) & 24'hFFFFFF;
                else           m_tgt = int'(r[23:0]) & 24'hFFFFFE;
                m_pc    = (m_pc + 2) & 24'hFFFFFF;
                m_slot  = 1;
                e.taken = 1;
            end else begin
                m_pc = (m_pc + 2) & 24'hFFFFFF;
            end
        end
        e.pc = m_pc[23:0]; e.target = m_tgt[23:0]; e.in_slot = m_slot;
        exp_q.push_back(e);
    endtask

    // monitor: compares one expected item per clock, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (pc !== e.pc || taken !== e.taken || target !== e.target ||
                in_slot !== e.in_slot || slot_error !== e.err) begin
                n_fail++;
                $display("FAIL %s: got pc=%h taken=%b target=%h slot=%b err=%b, expected pc=%h taken=%b target=%h slot=%b err=%b",
                         e.tag, pc, taken, target, in_slot, slot_error,
                         e.pc, e.taken, e.target, e.in_slot, e.err);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_kind = 2'd0; cond_code = '0;
        rel_offset = '0; jump_reg = '0; flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (pc !== 24'h0 || taken !== 1'b0 || target !== 24'h0 || in_slot !== 1'b0 || slot_error !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got pc=%h taken=%b target=%h slot=%b err=%b, expected all zero",
                     pc, taken, target, in_slot, slot_error);
        end
        rst_n = 1'b1;

        drive(1, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R1 first step after reset / R3 plain");
        drive(0, 2'd1, 5'd0,  5'd3,  32'h0, 3'b000, "R2 idle ignores branch");
        drive(1, 2'd3, 5'd0,  5'd0,  32'h0, 3'b000, "R3 kind 3 plain");
        drive(1, 2'd1, 5'd0,  5'd5,  32'h0, 3'b000, "R6 cond 0 taken, R7 forward offset");
        drive(1, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R9 slot redirect");
        drive(1, 2'd1, 5'h01, 5'd2,  32'h0, 3'b001, "R4 zero-clear fails");
        drive(1, 2'd1, 5'h02, 5'h1D, 32'h0, 3'b001, "R4 zero-set taken, R7 negative offset");
        drive(0, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R11 idle inside slot");
        drive(1, 2'd2, 5'd0,  5'd0,  32'h00FF_FF00, 3'b000, "R10 abs jump in slot");
        drive(1, 2'd2, 5'h04, 5'd0,  32'h0000_0100, 3'b010, "R5 carry-clear fails");
        drive(1, 2'd2, 5'h14, 5'd0,  32'hAB12_3457, 3'b010, "R5 neg-clear taken, R8 abs mask");
        drive(1, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R9 redirect to abs target");
        drive(1, 2'd1, 5'h08, 5'd0,  32'h0, 3'b010, "R5 carry-set taken");
        drive(1, 2'd1, 5'd0,  5'd7,  32'h0, 3'b000, "R10 rel branch in slot");
        drive(1, 2'd1, 5'h18, 5'd4,  32'h0, 3'b010, "R5 neg-set fails with N clear");
        drive(1, 2'd1, 5'h18, 5'd4,  32'h0, 3'b100, "R5 neg-set taken with N set");
        drive(1, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R9 slot");
        drive(1, 2'd1, 5'h03, 5'd1,  32'h0, 3'b000, "R6 zero conflict, Z clear");
        drive(1, 2'd1, 5'h03, 5'd1,  32'h0, 3'b001, "R6 zero conflict, Z set");
        drive(1, 2'd2, 5'h0C, 5'd0,  32'h0000_0040, 3'b010, "R6 flag conflict");
        drive(1, 2'd1, 5'h10, 5'h10, 32'h0, 3'b000, "R7 most negative offset");
        drive(1, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R9 slot after min offset");
        drive(0, 2'd0, 5'd0,  5'd0,  32'h0, 3'b000, "R2 trailing idle");

        repeat (4) @(posedge clk);
        #7;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule